// File: doc/BRIEF.md
# Byte and Half-Word Insert/Extract Unit

This unit lets a machine that only moves whole 32-bit words work with bytes and 16-bit half-words. A load extracts one byte or one half-word from a source word, at a byte lane chosen by the two low bits of the pointer linked to that operand, and sign- or zero-extends it. A store merges the low byte or low half-word of the operand into the selected lane of a destination word. Each operation also reports how far the linked pointer should advance, and raises a trap when a half-word would cross the word boundary. Fetching the next memory word when the pointer advances is left to the surrounding queue logic.

The operand is either a register value or a sign-extended 16-bit immediate. When the operand is a plain register with no linked pointer, the lane offset is taken as zero and a store writes the whole word. A dedicated high-half store, together with a preceding half-word store, builds any 32-bit constant in two operations. Each request is accepted on a clock edge with `op_valid` high, and its result is registered.

Top module: `ie_unit`

## Requirements
- R1: Opcode 0 (byte load, signed) and opcode 1 (byte load, unsigned) return operand bits [8k+7:8k], where k is the effective offset, sign-extended for opcode 0 and zero-extended for opcode 1.
- R2: Opcode 2 (half-word load, signed) and opcode 3 (half-word load, unsigned) return operand bits [8k+15:8k] extended in the same way, for k of 0, 1 or 2. For k equal to 3 these opcodes, and opcode 5, set `res_trap`, return `dst_word` unchanged and report a step of 0.
- R3: When `ptr_linked` is 0 the effective offset k is 0 whatever `ptr_low` holds, and no trap is raised.
- R4: Opcode 4 (byte store) with `ptr_linked` set returns `dst_word` with only byte lane k replaced by the operand's low byte (dst 12345678h, k 1, operand 9ABCDEF0h gives 1234F078h). With `ptr_linked` clear it returns the operand's low byte sign-extended to 32 bits.
- R5: Opcode 5 (half-word store) with `ptr_linked` set returns `dst_word` with bytes k and k+1 replaced by the operand's low half-word (dst 1234F078h, k 2, operand DEF0h gives DEF0F078h). With `ptr_linked` clear it returns the operand's low half-word sign-extended to 32 bits.
- R6: Opcodes 0, 1 and 4 report `res_step` 1; opcodes 2, 3 and 5 report `res_step` 2 when they do not trap.
- R7: Opcode 6 (high-half store) returns the operand's low 16 bits in bits 31:16 and `dst_word` bits 15:0 in bits 15:0, regardless of `ptr_linked` and `ptr_low`.
- R8: When `use_imm` is 1 the operand is `imm_val` sign-extended to 32 bits; otherwise it is `src_word`.
- R9: Opcode 7 (move) returns the operand unchanged with step 0 and no trap.
- R10: Opcode 6 always reports step 0 and never traps.
- R11: Results appear on the clock edge that accepts the request, with `res_valid` high for one cycle per request; without a request `res_valid` is 0 and the other outputs hold. Reset clears every output to 0.
- R12: Opcodes 8 to 15 set `res_trap`, return `dst_word` unchanged and report step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request accepted on this edge |
| op_code | input | 4 | Operation select |
| src_word | input | 32 | Register operand |
| imm_val | input | 16 | Immediate operand |
| use_imm | input | 1 | Select the immediate as operand |
| dst_word | input | 32 | Word being merged into |
| ptr_linked | input | 1 | Operand has a linked pointer |
| ptr_low | input | 2 | Low bits of the linked pointer |
| res_valid | output | 1 | Result valid pulse |
| res_word | output | 32 | Extracted or merged word |
| res_step | output | 2 | Pointer advance in bytes |
| res_trap | output | 1 | Misaligned or illegal operation |

## Verification
Every result, step and trap is due exactly one clock edge after the request is driven: the only register on the path is the output stage. The bench drives each request half a period before an edge and compares all outputs half a period after it, so each comparison lands on the one edge that produced it. Idle cycles are inserted to check that `res_valid` drops and the held outputs do not move. The sweep covers every opcode, every offset, linked and plain operands and both operand sources over several data patterns.

// File: rtl/ie_pkg.sv
package ie_pkg;
  typedef enum logic [3:0] {
    OP_LDB_S = 4'd0,
    OP_LDB_U = 4'd1,
    OP_LDH_S = 4'd2,
    OP_LDH_U = 4'd3,
    OP_STB   = 4'd4,
    OP_STH   = 4'd5,
    OP_STHI  = 4'd6,
    OP_MOVE  = 4'd7
  } ie_op_e;

  localparam int unsigned OPCODE_W = 4;
endpackage

// File: rtl/ie_operand.sv
module ie_operand #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [WORD_W-1:0] src_word,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              use_imm,
  input  logic              ptr_linked,
  input  logic [OFF_W-1:0]  ptr_low,
  output logic [WORD_W-1:0] opnd,
  output logic [OFF_W-1:0]  eff_off
);
  logic [WORD_W-1:0] imm_ext;

  // immediate is always widened with its top bit
  assign imm_ext = {{(WORD_W-IMM_W){imm_val[IMM_W-1]}}, imm_val};
  assign opnd    = use_imm ? imm_ext : src_word;
  // a plain register has no lane position
  assign eff_off = ptr_linked ? ptr_low : '0;
endmodule

// File: rtl/ie_extract.sv
module ie_extract #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned OFF_W   = 2
) (
  input  logic [WORD_W-1:0] opnd,
  input  logic [OFF_W-1:0]  off,
  input  logic              sign_ext,
  output logic [WORD_W-1:0] field_word
);
  localparam int unsigned LANE_SH = $clog2(LANE_W);

  logic [WORD_W-1:0]  shifted;
  logic [FIELD_W-1:0] field;
  logic               fill;

  assign shifted    = opnd >> {off, {LANE_SH{1'b0}}};
  assign field      = shifted[FIELD_W-1:0];
  assign fill       = sign_ext & field[FIELD_W-1];
  assign field_word = {{(WORD_W-FIELD_W){fill}}, field};
endmodule

// File: rtl/ie_insert.sv
module ie_insert #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned OFF_W   = 2
) (
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] opnd,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] merged
);
  localparam int unsigned LANES   = WORD_W / LANE_W;
  localparam int unsigned F_LANES = FIELD_W / LANE_W;
  localparam int unsigned LANE_SH = $clog2(LANE_W);
  localparam int unsigned CMP_W   = OFF_W + 2;

  logic [WORD_W-1:0] placed;
  logic [CMP_W-1:0]  lo_lane;
  logic [CMP_W-1:0]  hi_lane;

  assign placed  = {{(WORD_W-FIELD_W){1'b0}}, opnd[FIELD_W-1:0]} << {off, {LANE_SH{1'b0}}};
  assign lo_lane = {2'b00, off};
  assign hi_lane = lo_lane + CMP_W'(F_LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit;
    assign hit = (CMP_W'(k) >= lo_lane) && (CMP_W'(k) < hi_lane);
    assign merged[k*LANE_W +: LANE_W] = hit ? placed[k*LANE_W +: LANE_W]
                                            : dst[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ie_unit.sv
module ie_unit
  import ie_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES  = WORD_W / LANE_W,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned HALF_W = 2 * LANE_W,
  localparam int unsigned STEP_W = $clog2(HALF_W / LANE_W) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [OPCODE_W-1:0] op_code,
  input  logic [WORD_W-1:0]   src_word,
  input  logic [IMM_W-1:0]    imm_val,
  input  logic                use_imm,
  input  logic [WORD_W-1:0]   dst_word,
  input  logic                ptr_linked,
  input  logic [OFF_W-1:0]    ptr_low,
  output logic                res_valid,
  output logic [WORD_W-1:0]   res_word,
  output logic [STEP_W-1:0]   res_step,
  output logic                res_trap
);
  localparam logic [OFF_W-1:0] HALF_LAST = OFF_W'(LANES - HALF_W / LANE_W);

  logic [WORD_W-1:0] opnd;
  logic [OFF_W-1:0]  eff_off;
  logic [WORD_W-1:0] byte_ld, half_ld, byte_st, half_st;
  logic [WORD_W-1:0] byte_whole, half_whole;
  logic              half_bad;

  logic [WORD_W-1:0] nxt_word;
  logic [STEP_W-1:0] nxt_step;
  logic              nxt_trap;

  ie_operand #(.WORD_W(WORD_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_opnd (
    .src_word(src_word), .imm_val(imm_val), .use_imm(use_imm),
    .ptr_linked(ptr_linked), .ptr_low(ptr_low),
    .opnd(opnd), .eff_off(eff_off)
  );

  ie_extract #(.WORD_W(WORD_W), .FIELD_W(LANE_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_ext_b (
    .opnd(opnd), .off(eff_off), .sign_ext(op_code == OP_LDB_S), .field_word(byte_ld)
  );

  ie_extract #(.WORD_W(WORD_W), .FIELD_W(HALF_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_ext_h (
    .opnd(opnd), .off(eff_off), .sign_ext(op_code == OP_LDH_S), .field_word(half_ld)
  );

  ie_insert #(.WORD_W(WORD_W), .FIELD_W(LANE_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_ins_b (
    .dst(dst_word), .opnd(opnd), .off(eff_off), .merged(byte_st)
  );

  ie_insert #(.WORD_W(WORD_W), .FIELD_W(HALF_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_ins_h (
    .dst(dst_word), .opnd(opnd), .off(eff_off), .merged(half_st)
  );

  // plain-register stores fill the whole word
  assign byte_whole = {{(WORD_W-LANE_W){opnd[LANE_W-1]}}, opnd[LANE_W-1:0]};
  assign half_whole = {{(WORD_W-HALF_W){opnd[HALF_W-1]}}, opnd[HALF_W-1:0]};
  assign half_bad   = eff_off > HALF_LAST;

  always_comb begin
    nxt_word = dst_word;
    nxt_step = '0;
    nxt_trap = 1'b0;
    case (op_code)
      OP_LDB_S, OP_LDB_U: begin
        nxt_word = byte_ld;
        nxt_step = STEP_W'(1);
      end
      OP_LDH_S, OP_LDH_U: begin
        if (half_bad) begin
          nxt_trap = 1'b1;
        end else begin
          nxt_word = half_ld;
          nxt_step = STEP_W'(2);
        end
      end
      OP_STB: begin
        nxt_word = ptr_linked ? byte_st : byte_whole;
        nxt_step = STEP_W'(1);
      end
      OP_STH: begin
        if (half_bad) begin
          nxt_trap = 1'b1;
        end else begin
          nxt_word = ptr_linked ? half_st : half_whole;
          nxt_step = STEP_W'(2);
        end
      end
      OP_STHI: nxt_word = {opnd[WORD_W-HALF_W-1:0], dst_word[HALF_W-1:0]};
      OP_MOVE: nxt_word = opnd;
      default: nxt_trap = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      res_step  <= '0;
      res_trap  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_word <= nxt_word;
        res_step <= nxt_step;
        res_trap <= nxt_trap;
      end
    end
  end
endmodule

// File: rtl/ie_unit_chk.sv
module ie_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [31:0] src_word,
  input logic [15:0] imm_val,
  input logic        use_imm,
  input logic [31:0] dst_word,
  input logic        ptr_linked,
  input logic [1:0]  ptr_low,
  input logic        res_valid,
  input logic [31:0] res_word,
  input logic [1:0]  res_step,
  input logic        res_trap
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && $stable(res_word) && $stable(res_step)));

  assert_byte_step_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd0 || op_code == 4'd1 || op_code == 4'd4)) |=> (res_step == 2'd1));

  assert_half_trap_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ptr_linked && ptr_low == 2'd3 && (op_code == 4'd2 || op_code == 4'd3 || op_code == 4'd5))
    |=> (res_trap && res_step == 2'd0));

  assert_plain_no_trap_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ptr_linked && op_code < 4'd8) |=> !res_trap);

  assert_high_safe_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd6) |=> (!res_trap && res_step == 2'd0));

  assert_high_keeps_low_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd6) |=> (res_word[15:0] == $past(dst_word[15:0])));

  assert_byte_store_lane0_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd4 && ptr_linked && ptr_low == 2'd0)
    |=> (res_word[31:8] == $past(dst_word[31:8])));

  assert_illegal_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 4'd8) |=> (res_trap && res_word == $past(dst_word)));
endmodule

bind ie_unit ie_unit_chk u_chk (.*);

// File: tb/test_ie_unit.sv
module test_ie_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] src_word = '0;
  logic [15:0] imm_val = '0;
  logic        use_imm = 1'b0;
  logic [31:0] dst_word = '0;
  logic        ptr_linked = 1'b0;
  logic [1:0]  ptr_low = '0;
  logic        res_valid;
  logic [31:0] res_word;
  logic [1:0]  res_step;
  logic        res_trap;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ie_unit i_ie_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_word(src_word), .imm_val(imm_val), .use_imm(use_imm),
    .dst_word(dst_word), .ptr_linked(ptr_linked), .ptr_low(ptr_low),
    .res_valid(res_valid), .res_word(res_word), .res_step(res_step), .res_trap(res_trap)
  );

  task automatic check(input string req, input logic [31:0] got_w, input logic [31:0] exp_w,
                       input logic [1:0] got_s, input logic [1:0] exp_s,
                       input logic got_t, input logic exp_t, input logic got_v, input logic exp_v);
    tests++;
    if (got_w !== exp_w || got_s !== exp_s || got_t !== exp_t || got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: word %h step %0d trap %b valid %b, expected word %h step %0d trap %b valid %b",
               req, got_w, got_s, got_t, got_v, exp_w, exp_s, exp_t, exp_v);
    end
  endtask

  // arithmetic reference built from the requirements
  task automatic model(input logic [3:0] op, input logic [31:0] s, input logic [15:0] im,
                       input logic ui, input logic [31:0] d, input logic lk, input logic [1:0] lo,
                       output logic [31:0] w, output logic [1:0] st, output logic tr,
                       output string req);
    logic [31:0] o;
    int k;
    logic [7:0]  b;
    logic [15:0] h;
    o  = ui ? {{16{im[15]}}, im} : s;   // R8
    k  = lk ? int'(lo) : 0;             // R3
    w  = d; st = 2'd0; tr = 1'b0;
    b  = 8'((o / (32'd1 << (8*k))) % 256);
    h  = 16'((o / (32'd1 << (8*k))) % 65536);
    case (op)
      4'd0: begin w = {{24{b[7]}}, b}; st = 2'd1; req = "R1"; end
      4'd1: begin w = {24'd0, b}; st = 2'd1; req = "R1"; end
      4'd2, 4'd3: begin
        req = "R2";
        if (k == 3) tr = 1'b1;
        else begin w = (op == 4'd2) ? {{16{h[15]}}, h} : {16'd0, h}; st = 2'd2; end
      end
      4'd4: begin
        req = "R4"; st = 2'd1;
        if (lk) w[8*k +: 8] = o[7:0]; else w = {{24{o[7]}}, o[7:0]};
      end
      4'd5: begin
        req = "R5";
        if (k == 3) tr = 1'b1;
        else begin
          st = 2'd2;
          if (lk) w[8*k +: 16] = o[15:0]; else w = {{16{o[15]}}, o[15:0]};
        end
      end
      4'd6: begin w = {o[15:0], d[15:0]}; req = "R7_R10"; end
      4'd7: begin w = o; req = "R9"; end
      default: begin tr = 1'b1; req = "R12"; end
    endcase
    if (ui && op < 4'd8) req = {req, "_R8"};
    if (!lk && lo != 2'd0 && op < 4'd8) req = {req, "_R3"};
    if (op <= 4'd5 && !tr) req = {req, "_R6"};
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] s, input logic [15:0] im,
                       input logic ui, input logic [31:0] d, input logic lk, input logic [1:0] lo);
    logic [31:0] ew; logic [1:0] es; logic et; string rq;
    model(op, s, im, ui, d, lk, lo, ew, es, et, rq);
    op_valid = 1'b1; op_code = op; src_word = s; imm_val = im; use_imm = ui;
    dst_word = d; ptr_linked = lk; ptr_low = lo;
    @(posedge clk); @(negedge clk);
    check({rq, "_R11"}, res_word, ew, res_step, es, res_trap, et, res_valid, 1'b1);
  endtask

  task automatic idle();
    logic [31:0] hw; logic [1:0] hs; logic ht;
    hw = res_word; hs = res_step; ht = res_trap;
    op_valid = 1'b0; dst_word = ~dst_word; src_word = ~src_word;
    @(posedge clk); @(negedge clk);
    check("R11 idle hold", res_word, hw, res_step, hs, res_trap, ht, res_valid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h12345678; pats[1] = 32'h9ABCDEF0; pats[2] = 32'h80FF7F01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset state", res_word, 32'd0, res_step, 2'd0, res_trap, 1'b0, res_valid, 1'b0);

    // worked examples
    issue(4'd4, 32'h9ABCDEF0, 16'h0, 1'b0, 32'h12345678, 1'b1, 2'd1);          // R4
    issue(4'd5, 32'h0000DEF0, 16'h0, 1'b0, 32'h1234F078, 1'b1, 2'd2);          // R5
    issue(4'd5, 32'h0, 16'h5678, 1'b1, 32'h0, 1'b0, 2'd0);                     // R5 R8
    issue(4'd6, 32'h0, 16'h1234, 1'b1, 32'h00005678, 1'b0, 2'd0);              // R7
    check("R7 constant build", res_word, 32'h12345678, res_step, 2'd0, res_trap, 1'b0, res_valid, 1'b1);
    issue(4'd5, 32'h0, 16'h89AB, 1'b1, 32'h0, 1'b0, 2'd0);                     // R8
    check("R8 sign-extended immediate", res_word, 32'hFFFF89AB, res_step, 2'd2, res_trap, 1'b0, res_valid, 1'b1);
    idle();

    // exhaustive sweep over opcode, offset, link, operand source and data
    for (int op = 0; op < 16; op++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int lo = 0; lo < 4; lo++) begin
          for (int ui = 0; ui < 2; ui++) begin
            for (int p = 0; p < 3; p++) begin
              issue(4'(op), pats[p], pats[(p+1)%3][31:16] ^ 16'(lo), 1'(ui),
                    pats[(p+2)%3], 1'(lk), 2'(lo));
            end
          end
        end
      end
      idle();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule